// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is an SPI master that executes a list of transfers held in on-chip queue memory, with no processor involvement between transfers. Each of the 32 queue slots has a command word, a transmit word and a receive word. The command word gives a 4-bit peripheral-select code, a transfer length of 8 to 16 bits, and a flag that keeps the select code on the pins into the next slot. Software fills the command and transmit slots through a simple write port. It then sets the first and last slot, sets clock rate and polarity/phase, and issues a start strobe.

The sequencer runs the slots from the first pointer to the last. The pointer wraps from slot 31 to slot 0. For each slot it drives the select code on four pins for external decoding (up to 16 devices) and shifts the transmit word out MSB first. At the same time it shifts the receive word in and stores it in the receive slot. At the last slot it raises a sticky completion flag and, if enabled, an interrupt. In wrap mode it returns to the first slot and keeps running, raising the flag on every pass. A halt strobe ends the run once the transfer in progress completes.

Write port map: `wr_addr[7:6]`=00 selects command slot `wr_addr[4:0]`, 01 selects transmit slot `wr_addr[4:0]`. Address 0x80 is the configuration register, 0x81 the pointer register and 0x82 the strobe register.

Top module: `qspi_queue_master`

## Requirements
- R1: After reset: `sck`=0, `mosi`=0, `pcs`=4'hF, `busy`=0, `done`=0, `irq`=0.
- R2: Pointer register 0x81 holds the first slot in bits [4:0] and the last slot in bits [12:8]. Strobe bit 0 of 0x82 starts a run while idle. Slots run in order first, first+1, … last, with the index wrapping from 31 to 0. `busy` stays high until the run ends.
- R3: Command word fields: [3:0] select code, [7:4] length field, [8] use-length flag, [9] continue flag. With [8]=1 the transfer is 8+min(field,8) bits; with [8]=0 it is 8 bits. The low bits of the transmit word go out on `mosi`, MSB first.
- R4: The bits received on `miso` are stored right-aligned in the receive slot, with the upper bits zero. The receive slot is readable combinationally at `rd_addr`.
- R5: Configuration bits [7:0] give N. Each SCK half period lasts N clocks. N below 2 acts as 2.
- R6: Configuration bit 8 is CPOL: the SCK idle level is CPOL. Configuration bit 9 is CPHA. With CPHA=0, `miso` is sampled on leading edges and `mosi` changes on trailing edges. With CPHA=1 the two roles swap.
- R7: While a slot shifts, `pcs` carries its select code. While idle, `pcs` carries the idle code in configuration bits [15:12]. Between two slots, `pcs` shows the idle code for one clock unless the earlier slot has its continue flag set; in that case the select code is held.
- R8: `done` is set when the last slot completes. Strobe bit 2 clears it, and a set in the same cycle wins. `irq` is `done` gated by configuration bit 11.
- R9: With configuration bit 10 (wrap) set, the run resumes at the first slot after the last one and sets `done` again on each pass.
- R10: Strobe bit 1 (halt) during a run lets the current transfer finish, then stops with `busy`=0 and `pcs` at the idle code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for queue slots and registers |
| wr_addr | input | 8 | Write address (slot region or register) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 5 | Receive slot to read |
| rd_data | output | 16 | Receive slot contents |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| pcs | output | 4 | Encoded peripheral select |
| busy | output | 1 | Queue run in progress |
| done | output | 1 | Sticky completion flag |
| irq | output | 1 | Completion interrupt |

## Verification
The bench acts as a serial slave that decodes every SCK edge against the programmed polarity and phase. It goes after these cases:
- The length clamp at field values above 8: a wrong clamp would shift a 17+ bit or truncated word.
- A divider setting of 1: a missing floor would give a one-clock half period.
- A queue that crosses slot 31: a missing modulo step would run off the end or stop early.
- Select codes across slot boundaries, with and without the continue flag: a missing deselect gap, or one that should not be there, is caught at the first sample of the next slot.
- Wrap passes with the flag cleared between them, and halts placed mid-transfer: a wrong halt shows up as a run that stops one slot early or runs on past the slot in progress.

// File: rtl/qspi_pkg.sv
package qspi_pkg;
    typedef enum logic [1:0] {SQ_IDLE, SQ_LOAD, SQ_SHIFT} seq_st_e;

    localparam logic [7:0] REG_CFG  = 8'h80;
    localparam logic [7:0] REG_PTR  = 8'h81;
    localparam logic [7:0] REG_STB  = 8'h82;
    localparam logic [1:0] RGN_CMD  = 2'b00;
    localparam logic [1:0] RGN_TX   = 2'b01;
    localparam int         CMD_W    = 10;
endpackage

// File: rtl/qspi_baud.sv
module qspi_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } baud_s;

    baud_s q, d;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim  = (div < DIV_W'(2)) ? DIV_W'(2) : div;
        tick = en && (q.cnt == lim - 1'b1);
        d    = q;
        if (!en || tick) d.cnt = '0;
        else             d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/qspi_shifter.sv
module qspi_shifter #(
    parameter int WORD_W = 16,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  nbits,
    input  logic [WORD_W-1:0] tx,
    input  logic              cpha,
    input  logic              tick,
    input  logic              miso,
    output logic              run,
    output logic              tog,
    output logic              mosi,
    output logic              fin,
    output logic [WORD_W-1:0] rx
);
    typedef struct packed {
        logic              run;
        logic              tog;
        logic [CNT_W:0]    edg;
        logic [CNT_W-1:0]  n;
        logic [WORD_W-1:0] sh;
        logic [WORD_W-1:0] rx;
    } shf_s;

    shf_s q, d;
    logic lead;

    always_comb begin
        d    = q;
        fin  = 1'b0;
        lead = ~q.edg[0];
        if (!q.run) begin
            if (start) begin
                d.run = 1'b1;
                d.tog = 1'b0;
                d.edg = '0;
                d.n   = nbits;
                d.rx  = '0;
                d.sh  = tx << (CNT_W'(WORD_W) - nbits);
            end
        end else if (tick) begin
            if (q.edg == {q.n, 1'b0}) begin
                d.run = 1'b0;
                fin   = 1'b1;
            end else begin
                d.tog = ~q.tog;
                d.edg = q.edg + 1'b1;
                if (lead ^ cpha)          d.rx = {q.rx[WORD_W-2:0], miso};
                else if (q.edg != '0)     d.sh = {q.sh[WORD_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign run  = q.run;
    assign tog  = q.tog;
    assign mosi = q.sh[WORD_W-1];
    assign rx   = q.rx;
endmodule

// File: rtl/qspi_queue_master.sv
module qspi_queue_master
    import qspi_pkg::*;
#(
    parameter int  DEPTH  = 32,
    parameter int  WORD_W = 16,
    parameter int  DIV_W  = 8,
    localparam int PTR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [15:0]       wr_data,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [3:0]        pcs,
    output logic              busy,
    output logic              done,
    output logic              irq
);
    localparam int         CNT_W   = $clog2(WORD_W + 1);
    localparam logic [3:0] LEN_MAX = 4'(WORD_W - 8);

    typedef struct packed {
        seq_st_e          st;
        logic [PTR_W-1:0] ptr;
        logic [PTR_W-1:0] first;
        logic [PTR_W-1:0] last;
        logic [DIV_W-1:0] div;
        logic             cpol;
        logic             cpha;
        logic             wrap;
        logic             irq_en;
        logic [3:0]       idle_code;
        logic [3:0]       pcs;
        logic             halt_pend;
        logic             done;
    } ctl_s;

    ctl_s q, d;

    logic [CMD_W-1:0]  cmd_mem [DEPTH];
    logic [WORD_W-1:0] tx_mem  [DEPTH];
    logic [WORD_W-1:0] rx_mem  [DEPTH];

    logic              sh_start, sh_run, sh_tog, sh_fin, baud_tick, rx_we;
    logic [WORD_W-1:0] sh_rx;
    logic [CMD_W-1:0]  cur_cmd;
    logic [3:0]        len_f;
    logic [CNT_W-1:0]  nbits;
    logic              at_last;
    logic              unused_bits;

    assign unused_bits = ^{wr_data[15:13], wr_data[7:5]};

    always_comb begin
        d        = q;
        rx_we    = 1'b0;
        cur_cmd  = cmd_mem[q.ptr];
        len_f    = cur_cmd[7:4];
        if (len_f > LEN_MAX) len_f = LEN_MAX;
        nbits    = cur_cmd[8] ? CNT_W'(8) + CNT_W'(len_f) : CNT_W'(8);
        sh_start = (q.st == SQ_LOAD);
        at_last  = (q.ptr == q.last);

        if (wr_en && wr_addr == REG_CFG) begin
            d.div       = wr_data[DIV_W-1:0];
            d.cpol      = wr_data[8];
            d.cpha      = wr_data[9];
            d.wrap      = wr_data[10];
            d.irq_en    = wr_data[11];
            d.idle_code = wr_data[15:12];
        end
        if (wr_en && wr_addr == REG_PTR) begin
            d.first = wr_data[PTR_W-1:0];
            d.last  = wr_data[8+PTR_W-1:8];
        end
        if (wr_en && wr_addr == REG_STB) begin
            if (wr_data[2])                   d.done      = 1'b0;
            if (wr_data[1] && q.st != SQ_IDLE) d.halt_pend = 1'b1;
        end

        case (q.st)
            SQ_IDLE: begin
                if (wr_en && wr_addr == REG_STB && wr_data[0]) begin
                    d.ptr       = q.first;
                    d.st        = SQ_LOAD;
                    d.halt_pend = 1'b0;
                end
            end
            SQ_LOAD: begin
                d.pcs = cur_cmd[3:0];
                d.st  = SQ_SHIFT;
            end
            default: begin
                if (sh_fin) begin
                    rx_we = 1'b1;
                    if (at_last) d.done = 1'b1;
                    if (d.halt_pend || (at_last && !q.wrap)) begin
                        d.st        = SQ_IDLE;
                        d.halt_pend = 1'b0;
                    end else begin
                        d.st  = SQ_LOAD;
                        d.ptr = at_last ? q.first : q.ptr + 1'b1;
                        d.pcs = cur_cmd[9] ? q.pcs : q.idle_code;
                    end
                end
            end
        endcase

        if (d.st == SQ_IDLE) d.pcs = d.idle_code;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q           <= '0;
            q.st        <= SQ_IDLE;
            q.div       <= DIV_W'(2);
            q.idle_code <= 4'hF;
            q.pcs       <= 4'hF;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && wr_addr[7:6] == RGN_CMD) cmd_mem[wr_addr[PTR_W-1:0]] <= wr_data[CMD_W-1:0];
        if (wr_en && wr_addr[7:6] == RGN_TX)  tx_mem[wr_addr[PTR_W-1:0]]  <= wr_data[WORD_W-1:0];
        if (rx_we)                            rx_mem[q.ptr]               <= sh_rx;
    end

    qspi_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .en(sh_run), .div(q.div), .tick(baud_tick)
    );

    qspi_shifter #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(sh_start), .nbits(nbits),
        .tx(tx_mem[q.ptr]), .cpha(q.cpha), .tick(baud_tick), .miso(miso),
        .run(sh_run), .tog(sh_tog), .mosi(mosi), .fin(sh_fin), .rx(sh_rx)
    );

    assign rd_data = rx_mem[rd_addr];
    assign sck     = q.cpol ^ sh_tog;
    assign pcs     = q.pcs;
    assign busy    = (q.st != SQ_IDLE);
    assign done    = q.done;
    assign irq     = q.done & q.irq_en;
endmodule

// File: rtl/qspi_queue_checker.sv
module qspi_queue_checker #(
    parameter int PTR_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             sck,
    input logic             cpol,
    input logic [3:0]       pcs,
    input logic [3:0]       idle_code,
    input logic             done,
    input logic             fin,
    input logic             halt_pend,
    input logic             wrap,
    input logic [PTR_W-1:0] ptr,
    input logic [PTR_W-1:0] first,
    input logic [PTR_W-1:0] last
);
    // R6: serial clock rests at its polarity level whenever the queue is idle
    p_sck_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sck == cpol);

    // R7: select pins show the idle code whenever the queue is idle
    p_pcs_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> pcs == idle_code);

    // R2: a run begins at the first-slot pointer
    p_run_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ptr == first);

    // R8: completion flag only rises when a transfer finishes during a run
    p_done_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy) && $past(fin));

    // R10: the queue only stops at a transfer boundary
    p_stop_boundary_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(fin));

    // R9: in wrap mode the last slot leads back to the first one
    p_wrap_back_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && fin && ptr == last && wrap && !halt_pend |=> busy && ptr == first);
endmodule

bind qspi_queue_master qspi_queue_checker #(.PTR_W(PTR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .sck(sck), .cpol(q.cpol),
    .pcs(pcs), .idle_code(q.idle_code), .done(done), .fin(sh_fin),
    .halt_pend(q.halt_pend), .wrap(q.wrap), .ptr(q.ptr),
    .first(q.first), .last(q.last)
);

// File: tb/tb_qspi_queue_master.sv
module tb_qspi_queue_master;
    localparam int DEPTH = 32;

    logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, miso = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        sck, mosi, busy, done, irq;
    logic [3:0]  pcs;

    always #5 clk = ~clk;

    qspi_queue_master dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .sck(sck), .mosi(mosi), .miso(miso),
        .pcs(pcs), .busy(busy), .done(done), .irq(irq)
    );

    int checks = 0, errors = 0, cyc = 0;
    logic [3:0]  e_code [DEPTH];
    int          e_nb   [DEPTH];
    bit          e_cont [DEPTH];
    logic [15:0] e_tx   [DEPTH];
    logic [15:0] e_sl   [DEPTH];
    int          seq    [64];
    int          seq_len = 1;
    int          cur = 0, edges = 0, bitidx = 0, gap = 0, m_div = 2;
    logic [15:0] cap = '0;
    bit          saw_idle = 1, prev_cont = 0, mon_en = 0, m_cpol = 0, m_cpha = 0;
    logic [3:0]  m_idle = 4'hF;
    logic        prev_sck = 1'b0;

    function automatic logic [15:0] mask(int nb);
        return (nb >= 16) ? 16'hFFFF : 16'((1 << nb) - 1);
    endfunction

    function automatic int exp_nb(bit use_len, int field);
        if (!use_len) return 8;
        return 8 + ((field > 8) ? 8 : field);
    endfunction

    task automatic chk(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // serial slave model
    always @(negedge clk) begin
        int ent;
        if (mon_en) begin
            ent = seq[cur % seq_len];
            if (pcs == m_idle) saw_idle = 1;
            if (sck !== prev_sck) begin
                if (edges > 0) chk(gap == m_div, "R5 half period", gap, m_div);
                gap = 0;
                if (((prev_sck == m_cpol) ? 1'b1 : 1'b0) ^ m_cpha) begin
                    if (bitidx == 0) begin
                        chk(pcs == e_code[ent], "R7 select code", pcs, e_code[ent]);
                        chk(saw_idle == !prev_cont, "R7 select gap", saw_idle, !prev_cont);
                    end
                    cap = {cap[14:0], mosi};
                    bitidx++;
                    if (bitidx < e_nb[ent]) miso = e_sl[ent][e_nb[ent]-1-bitidx];
                end
                edges++;
                if (edges == 2 * e_nb[ent]) begin
                    chk(cap == (e_tx[ent] & mask(e_nb[ent])), "R3 R6 mosi word", cap,
                        e_tx[ent] & mask(e_nb[ent]));
                    prev_cont = e_cont[ent];
                    cur++;
                    edges = 0; bitidx = 0; cap = '0; saw_idle = 0;
                    ent = seq[cur % seq_len];
                    miso = e_sl[ent][e_nb[ent]-1];
                end
            end
            gap++;
        end
        prev_sck = sck;
    end

    task automatic wr(logic [7:0] a, logic [15:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_entry(int idx, logic [3:0] code, int field, bit use_len, bit cont,
                             logic [15:0] tx, logic [15:0] sl);
        e_code[idx] = code; e_nb[idx] = exp_nb(use_len, field); e_cont[idx] = cont;
        e_tx[idx] = tx; e_sl[idx] = sl;
        wr(8'(idx), {6'd0, cont, use_len, 4'(field), code});
        wr(8'h40 | 8'(idx), tx);
    endtask

    task automatic rand_entry(int idx, logic [3:0] idle);
        logic [3:0] code;
        code = 4'(idle + 1 + ($urandom % 15));
        set_entry(idx, code, $urandom % 16, 1'($urandom), 1'($urandom),
                  16'($urandom), 16'($urandom));
    endtask

    task automatic setup(int s, int e, bit wrap, int div, bit cpol, bit cpha, bit ien,
                         logic [3:0] idle);
        seq_len = ((e - s + DEPTH) % DEPTH) + 1;
        for (int i = 0; i < seq_len; i++) seq[i] = (s + i) % DEPTH;
        m_div = (div < 2) ? 2 : div; m_cpol = cpol; m_cpha = cpha; m_idle = idle;
        wr(8'h80, {idle, ien, wrap, cpha, cpol, 8'(div)});
        wr(8'h81, {3'd0, 5'(e), 3'd0, 5'(s)});
        wr(8'h82, 16'h0004);
        cur = 0; edges = 0; bitidx = 0; gap = 0; cap = '0;
        saw_idle = 1; prev_cont = 0;
        miso = e_sl[seq[0]][e_nb[seq[0]]-1];
        mon_en = 1;
    endtask

    task automatic wait_idle();
        int t = 0;
        while (busy && t < 60000) begin
            @(negedge clk);
            t++;
        end
        chk(!busy, "R2 run ends", busy, 0);
        mon_en = 0;
    endtask

    task automatic wait_point(int n, int ed);
        int t = 0;
        while (!(cur > n || (cur == n && edges >= ed)) && t < 60000) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic end_checks(bit ien);
        chk(cur == seq_len, "R2 slots run", cur, seq_len);
        chk(done == 1'b1, "R8 done set", done, 1);
        chk(irq == ien, "R8 irq gating", irq, ien);
        chk(pcs == m_idle, "R7 idle code", pcs, m_idle);
        chk(sck == m_cpol, "R6 idle level", sck, m_cpol);
        for (int i = 0; i < seq_len; i++) begin
            int ent = seq[i];
            rd_addr = 5'(ent);
            #1;
            chk(rd_data == (e_sl[ent] & mask(e_nb[ent])), "R4 receive slot", rd_data,
                e_sl[ent] & mask(e_nb[ent]));
        end
    endtask

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(sck == 0 && mosi == 0, "R1 serial pins", {sck, mosi}, 0);
        chk(pcs == 4'hF, "R1 select pins", pcs, 4'hF);
        chk(!busy && !done && !irq, "R1 flags", {busy, done, irq}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 length clamps, R5 divider floor of 2
        set_entry(0, 4'h1, 5,  0, 0, 16'hA5C3, 16'h3C5A);
        set_entry(1, 4'h2, 8,  1, 1, 16'h8001, 16'hF00F);
        set_entry(2, 4'h0, 15, 1, 0, 16'h1234, 16'hBEEF);
        set_entry(3, 4'h7, 3,  1, 0, 16'h05AB, 16'h0777);
        setup(0, 3, 0, 1, 0, 0, 1, 4'hF);
        wr(8'h82, 16'h0001);
        wait_idle();
        end_checks(1);

        // R2 pointer wrap 31 -> 0, CPOL=1 CPHA=1
        for (int i = 30; i < 34; i++) rand_entry(i % DEPTH, 4'h9);
        setup(30, 1, 0, 3, 1, 1, 0, 4'h9);
        wr(8'h82, 16'h0001);
        wait_idle();
        end_checks(0);

        // random runs, all modes
        for (int r = 0; r < 6; r++) begin
            int s = $urandom % DEPTH;
            int n = 1 + ($urandom % 6);
            logic [3:0] idl = 4'($urandom);
            for (int i = 0; i < n; i++) rand_entry((s + i) % DEPTH, idl);
            setup(s, (s + n - 1) % DEPTH, 0, 1 + ($urandom % 4), 1'($urandom), 1'($urandom),
                  1'($urandom), idl);
            wr(8'h82, 16'h0001);
            wait_idle();
            end_checks(1'(dut.q.irq_en));
        end

        // R10 halt in a single-pass run
        for (int i = 8; i < 16; i++) rand_entry(i, 4'h3);
        setup(8, 15, 0, 2, 0, 1, 0, 4'h3);
        wr(8'h82, 16'h0001);
        wait_point(2, 2);
        wr(8'h82, 16'h0002);
        wait_idle();
        chk(cur == 3, "R10 halt after current", cur, 3);
        chk(done == 0, "R10 end slot not reached", done, 0);
        chk(pcs == 4'h3, "R10 select released", pcs, 4'h3);

        // R9 wrap passes, R8 clear
        rand_entry(5, 4'hC); rand_entry(6, 4'hC);
        setup(5, 6, 1, 2, 1, 0, 1, 4'hC);
        wr(8'h82, 16'h0001);
        wait_point(2, 1);
        chk(done == 1 && irq == 1, "R9 first pass flag", {done, irq}, 3);
        wr(8'h82, 16'h0004);
        chk(done == 0, "R8 flag cleared", done, 0);
        wait_point(4, 1);
        chk(done == 1, "R9 second pass flag", done, 1);
        chk(busy == 1, "R9 keeps running", busy, 1);
        wait_point(5, 2);
        wr(8'h82, 16'h0002);
        wait_idle();
        chk(cur == 6, "R10 halt in wrap", cur, 6);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule